// File: doc/BRIEF.md
# Converter power-state and clock-mode controller

This block sits beside the successive-approximation core of a small serial converter and decides whether the core is powered, whether its reference is enabled, and which clock paces the bit decisions. The serial front end hands it one pulse per accepted control byte, together with two decoded bits: one requesting full operation or power-down, and one choosing the external serial clock or the internal timer as the conversion clock. A three-level shutdown pin, seen as two digital flags, can override all software requests.

In internal-clock mode the block runs its own conversion timer. The timer advances one SAR bit every `CYC_PER_BIT` system clocks for `N_BITS` bits, and the strobe output stays low as a busy flag for that whole window. In external-clock mode the core reports completion through `ext_done`. A software power-down request takes effect only once the current conversion has finished. A low shutdown level cuts power and aborts the conversion at once.

Top module: `adc_pwr_ctrl`

## Requirements
- R1: After reset with the shutdown pin floating (both flags 0): pwr_on=1, ref_en=1, ext_clk_mode=0, strobe=1, strobe_oe=1, conv_busy=0, result_valid=0.
- R2: A conv_start pulse with ctl_ext_clk=1 sets ext_clk_mode=1 on the next cycle. conv_busy then stays 1 and strobe stays 1 until an ext_done pulse, and conv_done pulses for one cycle on the cycle after that. With ctl_ext_clk=0, ext_clk_mode becomes 0.
- R3: An internal-mode conversion holds strobe low for exactly CYC_PER_BIT*N_BITS cycles (32 by default), starting the cycle after conv_start. On the cycle strobe returns high, conv_done=1 and result_valid=1.
- R4: During an internal conversion sar_tick pulses exactly N_BITS times, once every CYC_PER_BIT cycles.
- R5: With ctl_pwr_up=0, pwr_on stays 1 through the conversion and falls together with conv_done. ref_en falls with it.
- R6: conv_start received while powered down sets pwr_on=1 on the next cycle. With ctl_pwr_up=1, pwr_on stays 1 after the conversion.
- R7: Shutdown low (shdn_lo=1; shdn_lo=1 with shdn_hi=1 is also treated as low) forces pwr_on=0 and ref_en=0 in the same cycle. If a conversion was running, abort_conv pulses for one cycle on the next cycle and conv_busy becomes 0, with no conv_done. conv_start is ignored while shutdown is low.
- R8: shdn_hi=1 alone keeps the power state but forces ref_en=0. With the pin floating, ref_en equals pwr_on.
- R9: In internal-clock mode strobe_oe=1 whatever cs_n does, and cs_n does not change the conversion length. In external-clock mode strobe_oe equals the inverse of cs_n.
- R10: result_valid stays 1 after a software power-down until the next accepted conv_start clears it.
- R11: conv_start during a running conversion gives a one-cycle abort_conv pulse on the next cycle and starts a new conversion of full length.
- R12: An ext_done pulse when no external-clock conversion is running has no effect: conv_done stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| conv_start | input | 1 | One-cycle pulse: control byte accepted, start conversion |
| ctl_pwr_up | input | 1 | Decoded request: 1 full operation, 0 power down after conversion |
| ctl_ext_clk | input | 1 | Decoded request: 1 external clock, 0 internal timer |
| ext_done | input | 1 | Core reports end of an external-clock conversion |
| cs_n | input | 1 | Active-low chip select |
| shdn_lo | input | 1 | Shutdown pin driven low |
| shdn_hi | input | 1 | Shutdown pin driven high |
| pwr_on | output | 1 | Core power enable |
| ref_en | output | 1 | Internal reference enable |
| ext_clk_mode | output | 1 | 1 when the external clock paces conversions |
| conv_busy | output | 1 | A conversion is running |
| abort_conv | output | 1 | One-cycle pulse: running conversion discarded |
| conv_done | output | 1 | One-cycle pulse: conversion completed |
| sar_tick | output | 1 | Internal timer bit-step pulse |
| strobe | output | 1 | Busy strobe, low while internal conversion runs |
| strobe_oe | output | 1 | Strobe output enable |
| result_valid | output | 1 | A completed result is held for readout |

## Verification
The hardest situations to reach are the collisions. One is a shutdown that arrives part-way through an internal conversion. The other is a new start arriving while an earlier conversion is still running. Both need a conversion already in flight when the second event lands. The stimulus first launches an internal conversion and waits a chosen number of cycles. It then raises the shutdown flag, or issues another start, and checks the abort pulse, the missing completion and the restarted full-length strobe window. Random rounds mix clock modes, power requests and shutdown levels, and each round's expected power and reference state comes from bench functions.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

    typedef enum logic [1:0] {
        LVL_FLOAT = 2'd0,
        LVL_HIGH  = 2'd1,
        LVL_LOW   = 2'd2
    } shdn_lvl_e;

    typedef struct packed {
        logic sw_up;       // software power state
        logic ext_mode;    // last selected clock mode
        logic pd_pending;  // power down once conversion ends
        logic ext_busy;    // external-clock conversion running
        logic res_valid;   // completed result held
        logic abort;       // abort pulse
        logic done;        // completion pulse
    } ctl_state_t;

endpackage

// File: rtl/adc_shdn_decode.sv
module adc_shdn_decode
    import adc_pwr_pkg::*;
(
    input  logic      pin_lo,
    input  logic      pin_hi,
    output shdn_lvl_e lvl
);
    // Both flags together are treated as the safe (powered-down) level.
    always_comb begin
        if (pin_lo)      lvl = LVL_LOW;
        else if (pin_hi) lvl = LVL_HIGH;
        else             lvl = LVL_FLOAT;
    end
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
    parameter int CYC_PER_BIT = 4,
    parameter int N_BITS      = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic kill_i,
    output logic busy_o,
    output logic tick_o,
    output logic fin_o
);
    localparam int CW = $clog2(CYC_PER_BIT + 1);
    localparam int BW = $clog2(N_BITS + 1);
    localparam logic [CW-1:0] CYC_LAST = CW'(CYC_PER_BIT - 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(N_BITS - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cyc;
        logic [BW-1:0] bits;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic tick_raw, fin_raw;

    always_comb begin
        tmr_d    = tmr_q;
        tick_raw = tmr_q.busy && (tmr_q.cyc == CYC_LAST);
        fin_raw  = tick_raw && (tmr_q.bits == BIT_LAST);
        if (tmr_q.busy) begin
            if (tick_raw) begin
                tmr_d.cyc  = '0;
                tmr_d.bits = tmr_q.bits + 1'b1;
                if (fin_raw) begin
                    tmr_d.busy = 1'b0;
                    tmr_d.bits = '0;
                end
            end else begin
                tmr_d.cyc = tmr_q.cyc + 1'b1;
            end
        end
        if (kill_i) begin
            tmr_d = '0;
        end
        if (start_i) begin
            tmr_d      = '0;
            tmr_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy_o = tmr_q.busy;
    assign tick_o = tick_raw && !kill_i;
    assign fin_o  = fin_raw && !kill_i;

    // R4: counters never leave their range
    assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.cyc <= CYC_LAST) && (tmr_q.bits <= BIT_LAST));

    // R3: busy only ends through completion or a kill
    assert_busy_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tmr_q.busy) |-> $past(fin_o || kill_i));
endmodule

// File: rtl/adc_pwr_ctrl.sv
module adc_pwr_ctrl
    import adc_pwr_pkg::*;
#(
    parameter int CYC_PER_BIT = 4,
    parameter int N_BITS      = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_start,
    input  logic ctl_pwr_up,
    input  logic ctl_ext_clk,
    input  logic ext_done,
    input  logic cs_n,
    input  logic shdn_lo,
    input  logic shdn_hi,
    output logic pwr_on,
    output logic ref_en,
    output logic ext_clk_mode,
    output logic conv_busy,
    output logic abort_conv,
    output logic conv_done,
    output logic sar_tick,
    output logic strobe,
    output logic strobe_oe,
    output logic result_valid
);
    shdn_lvl_e  lvl;
    ctl_state_t state_d, state_q;
    logic       off, start_ok, tmr_start, tmr_kill;
    logic       tmr_busy, tmr_tick, tmr_fin, busy_any, finish;

    adc_shdn_decode u_shdn (
        .pin_lo (shdn_lo),
        .pin_hi (shdn_hi),
        .lvl    (lvl)
    );

    assign off       = (lvl == LVL_LOW);
    assign start_ok  = conv_start && !off;
    assign tmr_start = start_ok && !ctl_ext_clk;
    assign tmr_kill  = off || start_ok;

    adc_conv_timer #(
        .CYC_PER_BIT (CYC_PER_BIT),
        .N_BITS      (N_BITS)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tmr_start),
        .kill_i  (tmr_kill),
        .busy_o  (tmr_busy),
        .tick_o  (tmr_tick),
        .fin_o   (tmr_fin)
    );

    assign busy_any = tmr_busy || state_q.ext_busy;
    assign finish   = tmr_fin || (state_q.ext_busy && ext_done);

    always_comb begin
        state_d       = state_q;
        state_d.abort = 1'b0;
        state_d.done  = 1'b0;
        if (off) begin
            state_d.abort      = busy_any;
            state_d.ext_busy   = 1'b0;
            state_d.pd_pending = 1'b0;
        end else if (conv_start) begin
            state_d.abort      = busy_any;
            state_d.sw_up      = 1'b1;
            state_d.ext_mode   = ctl_ext_clk;
            state_d.pd_pending = !ctl_pwr_up;
            state_d.ext_busy   = ctl_ext_clk;
            state_d.res_valid  = 1'b0;
        end else if (finish) begin
            state_d.ext_busy  = 1'b0;
            state_d.res_valid = 1'b1;
            state_d.done      = 1'b1;
            if (state_q.pd_pending) begin
                state_d.sw_up      = 1'b0;
                state_d.pd_pending = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q       <= '0;
            state_q.sw_up <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign pwr_on       = state_q.sw_up && !off;
    assign ref_en       = pwr_on && (lvl == LVL_FLOAT);
    assign ext_clk_mode = state_q.ext_mode;
    assign conv_busy    = busy_any;
    assign abort_conv   = state_q.abort;
    assign conv_done    = state_q.done;
    assign sar_tick     = tmr_tick;
    assign strobe       = !tmr_busy;
    assign strobe_oe    = !state_q.ext_mode || !cs_n;
    assign result_valid = state_q.res_valid;

    // R7: a low shutdown level leaves nothing running and nothing completing
    assert_off_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        off |=> (!conv_busy && !conv_done));

    // R6: software power comes back only through an accepted start
    assert_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q.sw_up) |-> $past(conv_start));

    // R5: software power-down happens only together with a completion
    assert_pd_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state_q.sw_up) |-> conv_done);
endmodule

// File: tb/adc_pwr_ctrl_bench.sv
module adc_pwr_ctrl_bench;
    localparam int CPB = 4;
    localparam int NB  = 8;
    localparam int CONV_LEN = CPB * NB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_start = 0, ctl_pwr_up = 0, ctl_ext_clk = 0, ext_done = 0;
    logic cs_n = 1, shdn_lo = 0, shdn_hi = 0;
    logic pwr_on, ref_en, ext_clk_mode, conv_busy, abort_conv, conv_done;
    logic sar_tick, strobe, strobe_oe, result_valid;
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    adc_pwr_ctrl #(.CYC_PER_BIT(CPB), .N_BITS(NB)) u_adc_pwr_ctrl (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start),
        .ctl_pwr_up(ctl_pwr_up), .ctl_ext_clk(ctl_ext_clk),
        .ext_done(ext_done), .cs_n(cs_n), .shdn_lo(shdn_lo),
        .shdn_hi(shdn_hi), .pwr_on(pwr_on), .ref_en(ref_en),
        .ext_clk_mode(ext_clk_mode), .conv_busy(conv_busy),
        .abort_conv(abort_conv), .conv_done(conv_done),
        .sar_tick(sar_tick), .strobe(strobe), .strobe_oe(strobe_oe),
        .result_valid(result_valid)
    );

    function automatic logic exp_ref(input logic pwr, input logic lo, input logic hi);
        return pwr && !lo && !hi;
    endfunction

    task automatic chk(input string what, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", what, got, exp);
        end
    endtask

    task automatic start_conv(input logic pu, input logic ec);
        @(negedge clk);
        conv_start = 1; ctl_pwr_up = pu; ctl_ext_clk = ec;
        @(negedge clk);
        conv_start = 0;
    endtask

    // Called right after start_conv; returns at the first sample with strobe high.
    task automatic run_internal(output int len, output int ticks, output int pwr_low);
        len = 0; ticks = 0; pwr_low = 0;
        while (strobe === 1'b0 && len < 500) begin
            len++;
            ticks += int'(sar_tick);
            if (pwr_on !== 1'b1) pwr_low++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog R1 got=hang exp=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int len, ticks, pwr_low;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pwr_on", pwr_on, 1);
        chk("R1 ref_en", ref_en, 1);
        chk("R1 ext_clk_mode", ext_clk_mode, 0);
        chk("R1 strobe", strobe, 1);
        chk("R1 strobe_oe", strobe_oe, 1);
        chk("R1 conv_busy", conv_busy, 0);
        chk("R1 result_valid", result_valid, 0);

        // R12 stray ext_done while idle
        ext_done = 1;
        @(negedge clk);
        ext_done = 0;
        chk("R12 conv_done", conv_done, 0);

        // R3 R4 R9 internal conversion, cs_n toggled during it
        start_conv(1, 0);
        chk("R2 ext_clk_mode int", ext_clk_mode, 0);
        cs_n = 0;
        chk("R9 strobe_oe cs low", strobe_oe, 1);
        cs_n = 1;
        #1 chk("R9 strobe_oe cs high", strobe_oe, 1);
        run_internal(len, ticks, pwr_low);
        chk("R3 strobe low length", len, CONV_LEN);
        chk("R4 tick count", ticks, NB);
        chk("R3 conv_done", conv_done, 1);
        chk("R3 result_valid", result_valid, 1);
        chk("R6 pwr_on stays", pwr_on, 1);

        // R5 R10 software power-down in internal mode
        start_conv(0, 0);
        chk("R10 result cleared", result_valid, 0);
        run_internal(len, ticks, pwr_low);
        chk("R5 pwr during conv", pwr_low, 0);
        chk("R5 length", len, CONV_LEN);
        chk("R5 pwr_on after", pwr_on, 0);
        chk("R5 ref_en after", ref_en, 0);
        chk("R5 done with pd", conv_done, 1);
        repeat (5) @(negedge clk);
        chk("R10 result held", result_valid, 1);
        chk("R5 pwr stays off", pwr_on, 0);

        // R6 wake by start, R2 external mode
        start_conv(1, 1);
        chk("R6 wake", pwr_on, 1);
        chk("R2 ext_clk_mode", ext_clk_mode, 1);
        chk("R2 busy", conv_busy, 1);
        chk("R2 strobe high", strobe, 1);
        cs_n = 0;
        #1 chk("R9 ext oe cs low", strobe_oe, 1);
        cs_n = 1;
        #1 chk("R9 ext oe cs high", strobe_oe, 0);
        repeat (4) @(negedge clk);
        chk("R2 still busy", conv_busy, 1);
        ext_done = 1;
        @(negedge clk);
        ext_done = 0;
        chk("R2 done", conv_done, 1);
        chk("R2 busy end", conv_busy, 0);
        @(negedge clk);
        chk("R2 done one cycle", conv_done, 0);

        // R7 shutdown during internal conversion
        start_conv(1, 0);
        repeat (5) @(negedge clk);
        shdn_lo = 1;
        #1 chk("R7 pwr_on immediate", pwr_on, 0);
        chk("R7 ref_en immediate", ref_en, 0);
        @(negedge clk);
        chk("R7 abort", abort_conv, 1);
        chk("R7 busy cleared", conv_busy, 0);
        @(negedge clk);
        chk("R7 abort one cycle", abort_conv, 0);
        start_conv(1, 0);
        chk("R7 start ignored", conv_busy, 0);
        chk("R7 no done", conv_done, 0);
        shdn_hi = 1;  // both flags: still low level
        #1 chk("R7 both flags off", pwr_on, 0);
        shdn_lo = 0;
        #1 chk("R8 high keeps power", pwr_on, 1);
        chk("R8 high ref off", ref_en, 0);
        shdn_hi = 0;
        #1 chk("R8 float ref on", ref_en, 1);

        // R11 restart during conversion
        start_conv(1, 0);
        repeat (10) @(negedge clk);
        start_conv(1, 0);
        chk("R11 abort", abort_conv, 1);
        run_internal(len, ticks, pwr_low);
        chk("R11 full length", len, CONV_LEN);
        chk("R11 done", conv_done, 1);

        // random rounds
        for (int i = 0; i < 30; i++) begin
            logic pu, ec, hi;
            pu = 1'($urandom % 2);
            ec = 1'($urandom % 2);
            hi = 1'($urandom % 2);
            shdn_hi = hi;
            start_conv(pu, ec);
            chk("R2 rnd mode", ext_clk_mode, int'(ec));
            if (ec) begin
                int w;
                w = 1 + int'($urandom % 6);
                repeat (w) @(negedge clk);
                chk("R2 rnd busy", conv_busy, 1);
                ext_done = 1;
                @(negedge clk);
                ext_done = 0;
            end else begin
                run_internal(len, ticks, pwr_low);
                chk("R3 rnd length", len, CONV_LEN);
            end
            chk("R3 rnd done", conv_done, 1);
            chk("R5 rnd pwr", pwr_on, int'(pu));
            chk("R8 rnd ref", ref_en, int'(exp_ref(pu, 1'b0, hi)));
            repeat (1 + int'($urandom % 3)) @(negedge clk);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule